// File: doc/BRIEF.md
# Descriptor Ring Completion Controller

This block keeps the hardware-side accounting for two rings of 64-bit buffer descriptors, one for receive and one for transmit. Software describes each ring with a base address, stored as the physical address shifted right by three, and a size in entries. It hands entries to hardware by ringing a doorbell with a count. It returns finished entries by writing an acknowledge count. For each ring the block tracks the head index, the number of entries still owned by hardware and the number of completed entries that software has not yet acknowledged.

When the data mover finishes a buffer, it reports a one-cycle completion event that carries a byte length, a completion code and a timestamp-request flag. The block then builds the 64-bit completion status word for the entry at the head and classifies the code. Three outcomes are possible: the frame ended, the frame continues in the next entry, or the buffer is in error. Each ring has two sticky status bits: a threshold bit, set while the completed count is above a programmable high-watermark, and an overflow bit, set by an event that arrives when no entry is available. Software clears these bits by writing ones. A single registered interrupt line is driven from the enabled status bits.

Top module: `ring_cmp_ctrl`

## Requirements
- R1: After synchronous reset, every head index, available count, completed count, completion word, kind, status bit and the interrupt output is 0.
- R2: A doorbell of N adds N to that ring's available count. The sum is capped at the ring size.
- R3: A completion event with at least one entry available does three things. It advances the head by one, wrapping from size-1 to 0. It lowers the available count by one. It raises the completed count by one, saturating at the ring size.
- R4: A completion event while the available count is 0 changes no head, count, word or kind. It sets that ring's overflow status bit.
- R5: An acknowledge of N subtracts N from the completed count. If N exceeds the count, the count becomes 0.
- R6: The completion word is {2'b00, ts, code[4:0], len[15:0], addr[39:0]}. Here addr is base*8 + head*8, taken at the head before the event.
- R7: The completion kind is 1 (frame end) for code 0x0F, 2 (continues) for code 0x10 and 3 (error) for any other code. The value 0 appears only before the first accepted event.
- R8: Status bit 0 (receive) and bit 2 (transmit) set while the ring's completed count is strictly above its high-watermark. Bit 1 is the receive overflow and bit 3 is the transmit overflow.
- R9: A clear pulse clears each status bit whose mask bit is 1. A set condition in the same cycle wins over the clear.
- R10: The interrupt output is, one cycle later, the OR of the status bits ANDed with their enables. Enables never alter the status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_base | input | 2x37 | Ring base address shifted right by 3 (index 0 receive, 1 transmit) |
| ring_size | input | 2x10 | Ring size in entries, at least 1 |
| ring_hwm | input | 2x10 | Completed-count high-watermark |
| db_vld | input | 2 | Doorbell write strobe |
| db_cnt | input | 2x10 | Entries posted by the doorbell |
| ack_vld | input | 2 | Acknowledge write strobe |
| ack_cnt | input | 2x10 | Completed entries being acknowledged |
| ev_vld | input | 2 | Completion event pulse |
| ev_len | input | 2x16 | Completed buffer length in bytes |
| ev_code | input | 2x5 | Completion code |
| ev_ts | input | 2 | Timestamp-request flag of the entry |
| sts_clr_vld | input | 1 | Status clear strobe |
| sts_clr_mask | input | 4 | Write-one-to-clear mask |
| irq_en | input | 4 | Per-status-bit interrupt enables |
| head_idx | output | 2x9 | Head index |
| avail_cnt | output | 2x10 | Entries available to hardware |
| done_cnt | output | 2x10 | Completed, unacknowledged entries |
| cmp_word | output | 2x64 | Last completion status word |
| cmp_kind | output | 2x2 | Last completion classification |
| irq_sts | output | 4 | Sticky interrupt status |
| irq | output | 1 | Registered interrupt request |

## Verification
On every cycle the assertions check four things: the count caps, the head wrap, the freezing of ring state on an overflowing event and the clear-to-zero on an oversized acknowledge. They also check the status set, clear and priority rules and the one-cycle path from enabled status to the interrupt line. The bench scenarios show the actual values. These are the head, count and kind sequence on a four-entry receive ring through doorbell capping, wrap, saturation and error codes, and the exact bit layout of transmit completion words. The bench also shows that masking an interrupt leaves its status untouched.

// File: rtl/ring_cmp_pkg.sv
package ring_cmp_pkg;
    localparam int ADDR_W = 40;
    localparam int BASE_W = ADDR_W - 3;
    localparam int LEN_W  = 16;
    localparam int CODE_W = 5;
    localparam int WORD_W = 64;
    localparam int NSTS   = 4;

    localparam logic [CODE_W-1:0] CODE_END  = 5'h0F;
    localparam logic [CODE_W-1:0] CODE_MORE = 5'h10;

    typedef enum logic [1:0] {
        KIND_NONE = 2'd0,
        KIND_END  = 2'd1,
        KIND_MORE = 2'd2,
        KIND_ERR  = 2'd3
    } cmp_kind_e;

    typedef struct packed {
        logic [1:0]        rsvd;
        logic              ts;
        logic [CODE_W-1:0] code;
        logic [LEN_W-1:0]  len;
        logic [ADDR_W-1:0] addr;
    } cmp_word_t;

    function automatic cmp_kind_e classify(input logic [CODE_W-1:0] code);
        if (code == CODE_END)       return KIND_END;
        else if (code == CODE_MORE) return KIND_MORE;
        else                        return KIND_ERR;
    endfunction
endpackage

// File: rtl/ring_chan.sv
module ring_chan
    import ring_cmp_pkg::*;
#(
    parameter int MAX_ENTRIES = 512,
    localparam int CNT_W = $clog2(MAX_ENTRIES + 1),
    localparam int IDX_W = $clog2(MAX_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BASE_W-1:0] base,
    input  logic [CNT_W-1:0]  size,
    input  logic [CNT_W-1:0]  hwm,
    input  logic              db_vld,
    input  logic [CNT_W-1:0]  db_cnt,
    input  logic              ack_vld,
    input  logic [CNT_W-1:0]  ack_cnt,
    input  logic              ev_vld,
    input  logic [LEN_W-1:0]  ev_len,
    input  logic [CODE_W-1:0] ev_code,
    input  logic              ev_ts,
    output logic [IDX_W-1:0]  head,
    output logic [CNT_W-1:0]  avail,
    output logic [CNT_W-1:0]  done,
    output cmp_word_t         word,
    output cmp_kind_e         kind,
    output logic              thr_set,
    output logic              ovf_set
);
    logic              accept;
    logic [CNT_W:0]    a_sum, d_sum, d_sub, d_tmp;
    logic [CNT_W-1:0]  a_next, d_next;
    logic [IDX_W-1:0]  h_next;
    logic [ADDR_W-1:0] ent_addr;

    assign accept  = ev_vld && (avail != '0);
    assign ovf_set = ev_vld && (avail == '0);
    assign thr_set = done > hwm;

    always_comb begin
        a_sum  = {1'b0, avail} - {{CNT_W{1'b0}}, accept}
               + (db_vld ? {1'b0, db_cnt} : '0);
        a_next = (a_sum > {1'b0, size}) ? size : a_sum[CNT_W-1:0];
        d_sum  = {1'b0, done} + {{CNT_W{1'b0}}, accept};
        d_sub  = ack_vld ? {1'b0, ack_cnt} : '0;
        d_tmp  = (d_sub > d_sum) ? '0 : d_sum - d_sub;
        d_next = (d_tmp > {1'b0, size}) ? size : d_tmp[CNT_W-1:0];
        if (!accept)
            h_next = head;
        else if ({1'b0, head} == size - 1'b1)
            h_next = '0;
        else
            h_next = head + 1'b1;
        ent_addr = {base, 3'b000} + ADDR_W'({head, 3'b000});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head  <= '0;
            avail <= '0;
            done  <= '0;
            word  <= '0;
            kind  <= KIND_NONE;
        end else begin
            head  <= h_next;
            avail <= a_next;
            done  <= d_next;
            if (accept) begin
                word <= '{rsvd: 2'b00, ts: ev_ts, code: ev_code,
                          len: ev_len, addr: ent_addr};
                kind <= classify(ev_code);
            end
        end
    end

    a_r2_avail_cap: assert property (@(posedge clk) disable iff (rst)
        avail <= size);
    a_r3_done_cap: assert property (@(posedge clk) disable iff (rst)
        done <= size);
    a_r3_head_wrap: assert property (@(posedge clk) disable iff (rst)
        (ev_vld && avail != '0 && {1'b0, head} == size - 1'b1) |=> head == '0);
    a_r4_ovf_frozen: assert property (@(posedge clk) disable iff (rst)
        (ev_vld && avail == '0 && !db_vld) |=> ($stable(head) && avail == '0));
    a_r5_ack_clear: assert property (@(posedge clk) disable iff (rst)
        (ack_vld && !ev_vld && ack_cnt >= done) |=> done == '0);
endmodule

// File: rtl/irq_ctl.sv
module irq_ctl #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic         clr_vld,
    input  logic [N-1:0] clr_mask,
    input  logic [N-1:0] en,
    output logic [N-1:0] sts,
    output logic         irq
);
    logic [N-1:0] clr_bits;
    assign clr_bits = clr_vld ? clr_mask : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            sts <= '0;
            irq <= 1'b0;
        end else begin
            sts <= (sts & ~clr_bits) | set;
            irq <= |(sts & en);
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_chk
        a_r8_sticky_set: assert property (@(posedge clk) disable iff (rst)
            set[i] |=> sts[i]);
        a_r9_w1c: assert property (@(posedge clk) disable iff (rst)
            (clr_vld && clr_mask[i] && !set[i]) |=> !sts[i]);
        a_r10_en_no_touch: assert property (@(posedge clk) disable iff (rst)
            (sts[i] && !(clr_vld && clr_mask[i])) |=> sts[i]);
    end

    a_r10_irq_rise: assert property (@(posedge clk) disable iff (rst)
        (|(sts & en)) |=> irq);
    a_r10_irq_fall: assert property (@(posedge clk) disable iff (rst)
        !(|(sts & en)) |=> !irq);
endmodule

// File: rtl/ring_cmp_ctrl.sv
module ring_cmp_ctrl
    import ring_cmp_pkg::*;
#(
    parameter int MAX_ENTRIES = 512,
    localparam int CNT_W = $clog2(MAX_ENTRIES + 1),
    localparam int IDX_W = $clog2(MAX_ENTRIES)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [1:0][BASE_W-1:0]       ring_base,
    input  logic [1:0][CNT_W-1:0]        ring_size,
    input  logic [1:0][CNT_W-1:0]        ring_hwm,
    input  logic [1:0]                   db_vld,
    input  logic [1:0][CNT_W-1:0]        db_cnt,
    input  logic [1:0]                   ack_vld,
    input  logic [1:0][CNT_W-1:0]        ack_cnt,
    input  logic [1:0]                   ev_vld,
    input  logic [1:0][LEN_W-1:0]        ev_len,
    input  logic [1:0][CODE_W-1:0]       ev_code,
    input  logic [1:0]                   ev_ts,
    input  logic                         sts_clr_vld,
    input  logic [NSTS-1:0]              sts_clr_mask,
    input  logic [NSTS-1:0]              irq_en,
    output logic [1:0][IDX_W-1:0]        head_idx,
    output logic [1:0][CNT_W-1:0]        avail_cnt,
    output logic [1:0][CNT_W-1:0]        done_cnt,
    output logic [1:0][WORD_W-1:0]       cmp_word,
    output logic [1:0][1:0]              cmp_kind,
    output logic [NSTS-1:0]              irq_sts,
    output logic                         irq
);
    logic [1:0]      thr_set, ovf_set;
    logic [NSTS-1:0] set_vec;

    for (genvar d = 0; d < 2; d++) begin : g_ring
        cmp_word_t w;
        cmp_kind_e k;
        ring_chan #(.MAX_ENTRIES(MAX_ENTRIES)) u_chan (
            .clk     (clk),
            .rst     (rst),
            .base    (ring_base[d]),
            .size    (ring_size[d]),
            .hwm     (ring_hwm[d]),
            .db_vld  (db_vld[d]),
            .db_cnt  (db_cnt[d]),
            .ack_vld (ack_vld[d]),
            .ack_cnt (ack_cnt[d]),
            .ev_vld  (ev_vld[d]),
            .ev_len  (ev_len[d]),
            .ev_code (ev_code[d]),
            .ev_ts   (ev_ts[d]),
            .head    (head_idx[d]),
            .avail   (avail_cnt[d]),
            .done    (done_cnt[d]),
            .word    (w),
            .kind    (k),
            .thr_set (thr_set[d]),
            .ovf_set (ovf_set[d])
        );
        assign cmp_word[d] = w;
        assign cmp_kind[d] = k;
    end

    assign set_vec = {ovf_set[1], thr_set[1], ovf_set[0], thr_set[0]};

    irq_ctl #(.N(NSTS)) u_irq (
        .clk      (clk),
        .rst      (rst),
        .set      (set_vec),
        .clr_vld  (sts_clr_vld),
        .clr_mask (sts_clr_mask),
        .en       (irq_en),
        .sts      (irq_sts),
        .irq      (irq)
    );
endmodule

// File: tb/ring_cmp_ctrl_tb.sv
module ring_cmp_ctrl_tb;
    localparam int CNT_W = 10;
    localparam int IDX_W = 9;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0][36:0]      ring_base;
    logic [1:0][CNT_W-1:0] ring_size, ring_hwm, db_cnt, ack_cnt;
    logic [1:0]            db_vld, ack_vld, ev_vld, ev_ts;
    logic [1:0][15:0]      ev_len;
    logic [1:0][4:0]       ev_code;
    logic                  sts_clr_vld;
    logic [3:0]            sts_clr_mask, irq_en;
    logic [1:0][IDX_W-1:0] head_idx;
    logic [1:0][CNT_W-1:0] avail_cnt, done_cnt;
    logic [1:0][63:0]      cmp_word;
    logic [1:0][1:0]       cmp_kind;
    logic [3:0]            irq_sts;
    logic                  irq;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    ring_cmp_ctrl u_dut (.*);

    // op[27:24] 1=doorbell 2=event 3=ack, val[23:16], head, avail, done, kind
    localparam logic [27:0] VEC [0:10] = '{
        28'h1030300, 28'h20F1211, 28'h2102122, 28'h1052422,
        28'h20F3331, 28'h20F0241, 28'h20F1141, 28'h3011131,
        28'h3071101, 28'h2032013, 28'h20F2013
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        @(posedge clk); #1;
    endtask

    task automatic step_ev(input int d, input logic [15:0] len, input logic [4:0] code, input logic ts);
        ev_vld[d] = 1'b1; ev_len[d] = len; ev_code[d] = code; ev_ts[d] = ts;
        @(posedge clk); #1;
        ev_vld = '0;
    endtask

    task automatic step_db(input int d, input int n);
        db_vld[d] = 1'b1; db_cnt[d] = CNT_W'(n);
        @(posedge clk); #1;
        db_vld = '0;
    endtask

    task automatic step_ack(input int d, input int n);
        ack_vld[d] = 1'b1; ack_cnt[d] = CNT_W'(n);
        @(posedge clk); #1;
        ack_vld = '0;
    endtask

    task automatic clear_sts(input logic [3:0] m);
        sts_clr_vld = 1'b1; sts_clr_mask = m;
        @(posedge clk); #1;
        sts_clr_vld = 1'b0; sts_clr_mask = '0;
    endtask

    initial begin
        #100000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        ring_base = '0; ring_base[1] = 37'h100;
        ring_size[0] = 10'd4; ring_size[1] = 10'd8;
        ring_hwm[0] = 10'd1;  ring_hwm[1] = 10'd0;
        db_vld = '0; db_cnt = '0; ack_vld = '0; ack_cnt = '0;
        ev_vld = '0; ev_len = '0; ev_code = '0; ev_ts = '0;
        sts_clr_vld = 1'b0; sts_clr_mask = '0; irq_en = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        check("R1 head", 64'(head_idx), 64'h0);
        check("R1 avail", 64'(avail_cnt), 64'h0);
        check("R1 done", 64'(done_cnt), 64'h0);
        check("R1 word", cmp_word[0] | cmp_word[1], 64'h0);
        check("R1 kind", 64'(cmp_kind), 64'h0);
        check("R1 sts", 64'(irq_sts), 64'h0);
        check("R1 irq", 64'(irq), 64'h0);

        // R2 R3 R4 R5 R7 vector walk on the receive ring (size 4)
        for (int i = 0; i < 11; i++) begin
            case (VEC[i][27:24])
                4'd1: step_db(0, int'(VEC[i][23:16]));
                4'd2: step_ev(0, 16'h0010, VEC[i][20:16], 1'b0);
                default: step_ack(0, int'(VEC[i][23:16]));
            endcase
            check($sformatf("R2/R3/R4/R5 row%0d head", i), 64'(head_idx[0]), 64'(VEC[i][15:12]));
            check($sformatf("R2/R3/R4/R5 row%0d avail", i), 64'(avail_cnt[0]), 64'(VEC[i][11:8]));
            check($sformatf("R3/R5 row%0d done", i), 64'(done_cnt[0]), 64'(VEC[i][7:4]));
            check($sformatf("R7 row%0d kind", i), 64'(cmp_kind[0]), 64'(VEC[i][3:0]));
        end
        check("R4 R8 rx ovf and thr sticky", 64'(irq_sts), 64'h3);
        check("R10 irq masked", 64'(irq), 64'h0);
        check("R4 transmit untouched", 64'(avail_cnt[1]), 64'h0);

        // R9 clear both rx bits (done=1 not above hwm=1)
        clear_sts(4'b0011);
        check("R9 w1c", 64'(irq_sts), 64'h0);

        // R6 transmit completion words (base 0x100 -> addr 0x800)
        step_db(1, 2);
        step_ev(1, 16'h0040, 5'h0F, 1'b1);
        check("R6 word0", cmp_word[1], {2'b00, 1'b1, 5'h0F, 16'h0040, 40'h800});
        step_ev(1, 16'h003C, 5'h10, 1'b0);
        check("R6 word1", cmp_word[1], {2'b00, 1'b0, 5'h10, 16'h003C, 40'h808});
        check("R7 tx kind more", 64'(cmp_kind[1]), 64'h2);
        check("R8 tx thr hwm0", 64'(irq_sts), 64'h4);
        clear_sts(4'b0100);
        check("R9 set wins over clear", 64'(irq_sts[2]), 64'h1);

        // R8 R10 enables on the receive threshold
        step_db(0, 2);
        step_ev(0, 16'h0020, 5'h0F, 1'b0);
        idle();
        check("R8 rx thr set", 64'(irq_sts[0]), 64'h1);
        irq_en = 4'b0001;
        idle();
        check("R10 irq rises", 64'(irq), 64'h1);
        irq_en = 4'b0000;
        idle();
        check("R10 irq falls", 64'(irq), 64'h0);
        check("R10 status kept when masked", 64'(irq_sts[0]), 64'h1);
        step_ack(0, 2);
        step_ack(1, 2);
        clear_sts(4'b1111);
        check("R9 all cleared", 64'(irq_sts), 64'h0);
        irq_en = 4'b1111;
        idle();
        check("R10 no irq when clear", 64'(irq), 64'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule